// File: doc/BRIEF.md
# Interval Timer Channel with Gate Control Port

This block is one down-counting timer channel behind an 8-bit register interface, together with a small system control register. Software first writes a control byte that picks the channel, the byte access order, the counting mode and the number format. It then writes the 16-bit start count as two bytes, low byte first. The system control register drives the channel gate and a speaker enable. One of its bits reads back the live level of the channel output. Software polls that bit to learn when the count has run out.

Only terminal-count mode with binary counting and low-then-high access is built. Control bytes that ask for anything else, or that name another channel, are dropped with no effect. The timer clock is a one-cycle enable strobe in the bus clock domain.

Top module: `interval_timer_gate`

## Requirements
- R1: A write to port select 1 is a control byte: bits 7:6 are the channel, bits 5:4 the access mode, bits 3:1 the counting mode and bit 0 the BCD flag. It is accepted only when it names channel 2, access mode 3 (low then high), mode 0 and bit 0 clear, so 0xB0 is the accepted value. An accepted byte drives the output low, stops counting and expects a low byte next. Any other control byte changes nothing.
- R2: Writes to the count port (port select 0) are ignored until a control byte has been accepted after reset.
- R3: After an accepted control byte, the first count-port write is the low count byte and the second is the high byte. Counting starts with the cycle after the high byte. Each accepted count-port write drives the output low.
- R4: A low byte written on its own stops counting, and counting stays stopped until the matching high byte is written.
- R5: The counter moves down by one on each clock in which the tick strobe is high, counting is running and the gate is high. Cycles without the tick do not change it.
- R6: While the gate (system control bit 0) is low, the counter holds its value.
- R7: The output rises on the N-th qualifying tick after a load of N. A loaded value of 0 counts as 65536 ticks.
- R8: Once high, the output stays high, even while further ticks arrive, until a count-port write or an accepted control byte.
- R9: The speaker output equals the channel output AND system control bit 1.
- R10: A read at port select 2 returns the live channel output in bit 5. Bit 5 is not stored by writes.
- R11: The system control register keeps every written bit except bit 5 and returns those bits unchanged on reads, so a read-modify-write preserves the other bits. Port select 3 reads as zero, and reads at port selects 0 and 1 also return zero.
- R12: After reset the output and the speaker are low and the system control register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 2 | Port select: 0 count, 1 control, 2 system control, 3 unused |
| wr_en | input | 1 | Write strobe for the selected port |
| wdata | input | 8 | Write data byte |
| tick | input | 1 | Timer clock enable strobe |
| rdata | output | 8 | Read data for the selected port (combinational) |
| tmr_out | output | 1 | Channel output level |
| spkr_out | output | 1 | Gated speaker drive |

## Verification
Register writes take effect at the clock edge that samples them, so the output is checked on the next falling edge. The speaker output and the read data are combinational and are sampled 1 ns after the select changes. For a load of N, the output is due at the N-th ticking edge after the high-byte write. The bench drives the ticks from a falling edge and checks on the falling edge that follows the last one. It checks one tick before the expected rise, to see the output still low, and again at the rise.

// File: rtl/itg_pkg.sv
// Shared port codes and control-byte layout for the interval timer channel.
// Assumes an 8-bit bus and a 16-bit count.
package itg_pkg;
    localparam logic [1:0] PORT_COUNT = 2'd0;
    localparam logic [1:0] PORT_CTRL  = 2'd1;
    localparam logic [1:0] PORT_SYS   = 2'd2;

    localparam logic [1:0] ACC_LO_HI  = 2'b11;
    localparam logic [2:0] MODE_TERM  = 3'b000;

    typedef struct packed {
        logic [1:0] chan;
        logic [1:0] access;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_byte_t;
endpackage

// File: rtl/itg_ctrl_decode.sv
// Decodes a control byte and reports whether this channel accepts it.
// Assumes the byte uses the ctrl_byte_t layout; purely combinational.
module itg_ctrl_decode #(
    parameter int CH_ID = 2
) (
    input  logic [7:0] cw_byte,
    output logic       accept
);
    import itg_pkg::*;

    ctrl_byte_t cw;

    // Accept only this channel, low/high access, terminal-count mode, binary.
    always_comb begin
        cw     = ctrl_byte_t'(cw_byte);
        accept = (cw.chan == 2'(CH_ID)) && (cw.access == ACC_LO_HI) &&
                 (cw.mode == MODE_TERM) && !cw.bcd;
    end
endmodule

// File: rtl/itg_counter.sv
// Two-byte load sequencer, down counter and terminal-count output.
// Assumes cw_accept and data_wr are never high in the same cycle.
module itg_counter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_accept,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic              tick,
    input  logic              gate,
    output logic              out
);
    localparam int CNT_W = 2 * BYTE_W;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic              configured;
    logic              hi_next;
    logic              running;
    logic [BYTE_W-1:0] lo_hold;
    logic [CNT_W-1:0]  cnt;

    // Sequences control and count writes, counts down, raises out at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            configured <= 1'b0;
            hi_next    <= 1'b0;
            running    <= 1'b0;
            lo_hold    <= '0;
            cnt        <= '0;
            out        <= 1'b0;
        end else if (cw_accept) begin
            configured <= 1'b1;
            hi_next    <= 1'b0;
            running    <= 1'b0;
            out        <= 1'b0;
        end else if (data_wr && configured) begin
            out <= 1'b0;
            if (!hi_next) begin
                lo_hold <= data_byte;
                hi_next <= 1'b1;
                running <= 1'b0;
            end else begin
                cnt     <= {data_byte, lo_hold};
                hi_next <= 1'b0;
                running <= 1'b1;
            end
        end else if (running && tick && gate) begin
            cnt <= cnt - ONE;
            if (cnt == ONE) begin
                out <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/itg_sys_port.sv
// System control register: gate and speaker-enable bits, live status readback.
// Assumes the status bit position is not one of the control bit positions.
module itg_sys_port #(
    parameter int BYTE_W     = 8,
    parameter int GATE_BIT   = 0,
    parameter int SPK_BIT    = 1,
    parameter int STATUS_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rd_sel,
    input  logic              chan_out,
    output logic              gate,
    output logic              spk_en,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] ctl_q;
    logic [BYTE_W-1:0] view;

    // Stores the written byte; the status position is overridden on reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr) begin
            ctl_q <= wdata;
        end
    end

    // Builds the read view with the live output in the status position.
    always_comb begin
        view             = ctl_q;
        view[STATUS_BIT] = chan_out;
        rdata            = rd_sel ? view : '0;
    end

    assign gate   = ctl_q[GATE_BIT];
    assign spk_en = ctl_q[SPK_BIT];
endmodule

// File: rtl/interval_timer_gate.sv
// Top: one terminal-count timer channel plus its gate/speaker control port.
// Assumes a single-cycle write strobe and a tick strobe in the bus clock domain.
module interval_timer_gate #(
    parameter int BYTE_W = 8,
    parameter int CH_ID  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tick,
    output logic [BYTE_W-1:0] rdata,
    output logic              tmr_out,
    output logic              spkr_out
);
    import itg_pkg::*;

    logic cw_ok;
    logic gate;
    logic spk_en;
    logic wr_ctrl;
    logic wr_count;
    logic wr_sys;

    // Splits the write strobe by port select.
    always_comb begin
        wr_ctrl  = wr_en && (sel == PORT_CTRL);
        wr_count = wr_en && (sel == PORT_COUNT);
        wr_sys   = wr_en && (sel == PORT_SYS);
    end

    itg_ctrl_decode #(.CH_ID(CH_ID)) u_dec (
        .cw_byte (wdata[7:0]),
        .accept  (cw_ok)
    );

    itg_counter #(.BYTE_W(BYTE_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cw_accept (wr_ctrl && cw_ok),
        .data_wr   (wr_count),
        .data_byte (wdata),
        .tick      (tick),
        .gate      (gate),
        .out       (tmr_out)
    );

    itg_sys_port #(.BYTE_W(BYTE_W)) u_sys (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_sys),
        .wdata    (wdata),
        .rd_sel   (sel == PORT_SYS),
        .chan_out (tmr_out),
        .gate     (gate),
        .spk_en   (spk_en),
        .rdata    (rdata)
    );

    assign spkr_out = tmr_out && spk_en;
endmodule

// File: rtl/interval_timer_gate_chk.sv
// Port-level checker for interval_timer_gate, attached with bind.
// Assumes the default 8-bit bus and port codes from itg_pkg.
module interval_timer_gate_chk #(
    parameter int CH_ID = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] sel,
    input logic       wr_en,
    input logic [7:0] wdata,
    input logic       tick,
    input logic [7:0] rdata,
    input logic       tmr_out,
    input logic       spkr_out
);
    logic good_cw;
    assign good_cw = (wdata[7:6] == 2'(CH_ID)) && (wdata[5:0] == 6'b110000);

    AST_CTRL_CLEARS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 2'd1 && good_cw) |=> !tmr_out); // R1
    AST_COUNT_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 2'd0) |=> !tmr_out); // R3
    AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_out) |-> $past(tick)); // R5
    AST_OUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_out && !(wr_en && (sel == 2'd0 || sel == 2'd1))) |=> tmr_out); // R8
    AST_SPK_NEEDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        spkr_out |-> tmr_out); // R9
    AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd2) |-> (rdata[5] == tmr_out)); // R10
    AST_IDLE_PORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd3) |-> (rdata == 8'h00)); // R11
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!tmr_out && !spkr_out)); // R12
endmodule

bind interval_timer_gate interval_timer_gate_chk u_chk (.*);

// File: tb/interval_timer_gate_test.sv
module interval_timer_gate_test;
    localparam int CLK_PERIOD = 10;

    // {count[15:0], ticks[16:0], expected out}
    localparam logic [33:0] VEC [7] = '{
        {16'd5,    17'd4,    1'b0},
        {16'd5,    17'd5,    1'b1},
        {16'd1,    17'd1,    1'b1},
        {16'd1,    17'd0,    1'b0},
        {16'd256,  17'd255,  1'b0},
        {16'd256,  17'd256,  1'b1},
        {16'd4660, 17'd4660, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'd3;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       tick = 1'b0;
    logic [7:0] rdata;
    logic       tmr_out;
    logic       spkr_out;
    int         checks = 0;
    int         fails = 0;
    logic [7:0] rv;

    interval_timer_gate uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wdata(wdata),
        .tick(tick), .rdata(rdata), .tmr_out(tmr_out), .spkr_out(spkr_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        sel = s; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sel = 2'd3;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic load(input logic [15:0] v);
        wr(2'd1, 8'hB0);
        wr(2'd0, v[7:0]);
        wr(2'd0, v[15:8]);
    endtask

    task automatic rd_sys(output logic [7:0] v);
        sel = 2'd2;
        #1 v = rdata;
        sel = 2'd3;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 out", 16'(tmr_out), 16'd0);
        chk("R12 spkr", 16'(spkr_out), 16'd0);
        rd_sys(rv);
        chk("R12 sysreg", 16'(rv), 16'h00);

        // R2 count writes before any control byte are ignored
        wr(2'd2, 8'h01);
        wr(2'd0, 8'd2);
        wr(2'd0, 8'd0);
        ticks(5);
        chk("R2 unconfigured", 16'(tmr_out), 16'd0);

        // Vector table: R3 load order, R5 decrement, R7 terminal count, R9 speaker off
        for (int i = 0; i < 7; i++) begin
            load(VEC[i][33:18]);
            chk("R3 out low after load", 16'(tmr_out), 16'd0);
            ticks(int'(VEC[i][17:1]));
            chk("R7 vector", 16'(tmr_out), 16'(VEC[i][0]));
            chk("R9 speaker disabled", 16'(spkr_out), 16'd0);
        end

        // R5 sparse ticks
        load(16'd3);
        repeat (2) begin tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk); end
        chk("R5 two ticks", 16'(tmr_out), 16'd0);
        repeat (10) @(negedge clk);
        chk("R5 no tick no change", 16'(tmr_out), 16'd0);
        ticks(1);
        chk("R5 third tick", 16'(tmr_out), 16'd1);

        // R8 sticky under further ticks
        ticks(20);
        chk("R8 sticky", 16'(tmr_out), 16'd1);

        // R9 speaker, R10 status
        wr(2'd2, 8'h03);
        chk("R9 speaker on", 16'(spkr_out), 16'd1);
        rd_sys(rv);
        chk("R10 status high", 16'(rv), 16'h23);
        wr(2'd2, 8'h01);
        chk("R9 speaker off", 16'(spkr_out), 16'd0);
        chk("R9 timer still high", 16'(tmr_out), 16'd1);

        // R1 ignored control bytes: other channel, other mode, BCD, other access
        wr(2'd1, 8'h70);
        chk("R1 other channel", 16'(tmr_out), 16'd1);
        wr(2'd1, 8'hB2);
        chk("R1 other mode", 16'(tmr_out), 16'd1);
        wr(2'd1, 8'hB1);
        chk("R1 bcd", 16'(tmr_out), 16'd1);
        wr(2'd1, 8'h90);
        chk("R1 other access", 16'(tmr_out), 16'd1);
        wr(2'd1, 8'hB0);
        chk("R1 accepted clears", 16'(tmr_out), 16'd0);
        ticks(5);
        chk("R1 stopped", 16'(tmr_out), 16'd0);

        // R4 low byte alone stops counting
        load(16'd4);
        ticks(2);
        wr(2'd0, 8'd2);
        ticks(10);
        chk("R4 halted", 16'(tmr_out), 16'd0);
        wr(2'd0, 8'd0);
        ticks(1);
        chk("R4 one tick", 16'(tmr_out), 16'd0);
        ticks(1);
        chk("R4 reload done", 16'(tmr_out), 16'd1);

        // R8 count write clears
        wr(2'd0, 8'd5);
        chk("R8 count write clears", 16'(tmr_out), 16'd0);

        // R6 gate low holds
        wr(2'd2, 8'h00);
        load(16'd3);
        ticks(10);
        chk("R6 gate low", 16'(tmr_out), 16'd0);
        wr(2'd2, 8'h01);
        ticks(2);
        chk("R6 resumed", 16'(tmr_out), 16'd0);
        ticks(1);
        chk("R6 done", 16'(tmr_out), 16'd1);

        // R11 read-modify-write; R10 bit 5 not stored
        load(16'd9);
        wr(2'd2, 8'hCD);
        rd_sys(rv);
        chk("R11 readback", 16'(rv), 16'hCD);
        wr(2'd2, 8'hED);
        rd_sys(rv);
        chk("R10 bit5 live", 16'(rv), 16'hCD);
        sel = 2'd0;
        #1 chk("R11 count port reads zero", 16'(rdata), 16'h00);
        sel = 2'd3;
        #1 chk("R11 unused port", 16'(rdata), 16'h00);

        // R7 zero means 65536
        @(negedge clk);
        load(16'd0);
        ticks(65535);
        chk("R7 full range early", 16'(tmr_out), 16'd0);
        ticks(1);
        chk("R7 full range", 16'(tmr_out), 16'd1);

        finish_run();
    end
endmodule